// File: doc/BRIEF.md
# Rolling-Shutter Sparse Row Readout

This block steps a pixel matrix through its rows one at a time at a fixed rhythm and collects the hits found in each row. Every row stays selected for a fixed number of clock cycles. During that time the block asks the bank-level hit finders for their hits, taking at most one hit per cycle and always serving the lowest-numbered bank that has one waiting. A hit becomes one 32-bit word that records the row, the bank and the column inside the bank.

Only a limited number of words is kept for each row, and the limit is a parameter chosen from the expected occupancy. Hits drained beyond the limit are discarded, and the row is marked as overflowed. The kept words go into one half of a two-half buffer. While the next row is being collected, the other half streams the previous row's words out on a narrow serial lane, one slice per clock, so row stepping never waits for the link.

Two state machines do the work. The scan machine has the states `SCAN_IDLE` and `SCAN_RUN`. It moves from `SCAN_IDLE` to `SCAN_RUN` on `start` and then stays in `SCAN_RUN`. The transmit machine has the states `TX_IDLE` and `TX_SEND`. It moves from `TX_IDLE` to `TX_SEND` at a row boundary when the closing row holds at least one word. It moves from `TX_SEND` to `TX_IDLE` after the last slice of the last word, or at a row boundary when the closing row is empty. At a row boundary where the closing row holds words it stays in `TX_SEND` and begins the new row's words.

Top module: `rs_row_readout`

## Requirements
- R1: After reset, and until `start` is seen, these outputs stay at zero: `row_addr`, `bank_rd`, `frame_start`, `ser_valid`, `ser_data` and `tx_overflow`.
- R2: Once started, `row_addr` holds each value for exactly ROW_CYCLES (16) cycles and then rises by one. The first row after `start` is row 0.
- R3: After row ROWS-1 (1087) the next row is 0. `frame_start` is high for exactly one cycle, the first cycle of every row 0, and is low at all other times.
- R4: While scanning, `bank_rd` has at most one bit set in each cycle. That bit belongs to the lowest-indexed bank whose `bank_hit_valid` is high, and no bit is set for a bank without a valid hit. A strobed bank counts as drained by one hit at that clock edge.
- R5: A hit word holds the in-bank column in bits [5:0], the bank index in bits [10:6] and the row address in bits [21:11]. Bits [31:22] are zero.
- R6: Per row, the first MAX_HITS (8) drained hits, in drain order, are kept. Hits drained after that are still strobed and are discarded.
- R7: `tx_overflow` is high throughout the row period that follows a row in which at least one hit was discarded. It is low after a row with no discarded hit.
- R8: The words kept for row r are sent during the row period of row r+1, starting in its first cycle, in the order they were kept. Each word takes WORD_W/SER_W cycles with its upper 16 bits first. `ser_valid` is high for exactly those cycles, and `ser_data` is zero whenever `ser_valid` is low.
- R9: Collecting a row and sending the previous one overlap with no gap and no loss. A full row of MAX_HITS words is sent completely even when the next row is also full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| start | input | 1 | Begins rolling readout from row 0 |
| bank_hit_valid | input | 17 | One flag per bank: a hit is waiting |
| bank_hit_col | input | 102 | Column of each bank's waiting hit, 6 bits per bank, bank b at bits [6b+5:6b] |
| row_addr | output | 11 | Row currently selected |
| frame_start | output | 1 | First cycle of row 0 |
| bank_rd | output | 17 | Drain strobe, one bit per bank |
| ser_data | output | 16 | Serial slice of the current hit word |
| ser_valid | output | 1 | `ser_data` carries word data |
| tx_overflow | output | 1 | The row now being sent lost hits |

## Verification
Two situations are hard to reach from the ports. The first is a discard in the last drain cycle of a row, landing on the same edge as the buffer swap. The second is two back-to-back full rows, where one row's 16-cycle burst ends exactly as the next one starts. The stimulus reaches both with directed rows early in the first frame: a row with exactly eight hits, one with nine, and one with a hit in every bank, so the drain budget runs out before the last bank is served. Random rows with a fixed seed fill the rest of a full frame. The run continues past the wrap, which covers the return to row 0 and the second `frame_start`.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic {
        SCAN_IDLE,
        SCAN_RUN
    } scan_state_e;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

endpackage

// File: rtl/rs_bank_pick.sv
module rs_bank_pick #(
    parameter int BANKS = 17,
    localparam int IDX_W = $clog2(BANKS)
) (
    input  logic             en,
    input  logic [BANKS-1:0] req,
    output logic [BANKS-1:0] grant,
    output logic [IDX_W-1:0] idx
);

    // Walk from the top down so the lowest requesting bank wins last.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = BANKS - 1; i >= 0; i--) begin
            if (en && req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rs_hit_buffer.sv
module rs_hit_buffer
    import rs_pkg::*;
#(
    parameter int MAX_HITS = 8,
    parameter int WORD_W   = 32,
    parameter int SER_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic [WORD_W-1:0] word_in,
    input  logic              row_end,
    output logic [SER_W-1:0]  ser_data,
    output logic              ser_valid,
    output logic              tx_overflow
);

    localparam int CNT_W  = $clog2(MAX_HITS + 1);
    localparam int IDX_W  = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1;
    localparam int BEATS  = WORD_W / SER_W;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [WORD_W-1:0] mem [2][MAX_HITS];
    logic              fsel;
    logic [CNT_W-1:0]  fill_cnt;
    logic [CNT_W-1:0]  tx_cnt;
    logic [CNT_W-1:0]  load_cnt;
    logic              fill_ovf;
    logic              tx_ovf_q;
    logic              wr_en;
    logic              drop;
    logic [IDX_W-1:0]  tx_idx;
    logic [BEAT_W-1:0] beat;
    logic              last_beat;
    logic [WORD_W-1:0] tx_word;
    tx_state_e         tx_state;
    tx_state_e         tx_next;

    assign wr_en    = pop && (fill_cnt < CNT_W'(MAX_HITS));
    assign drop     = pop && !wr_en;
    assign load_cnt = fill_cnt + CNT_W'(wr_en);

    // Fill half: written in drain order, cleared at every row boundary.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[fsel][fill_cnt[IDX_W-1:0]] <= word_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsel     <= 1'b0;
            fill_cnt <= '0;
            fill_ovf <= 1'b0;
            tx_cnt   <= '0;
            tx_ovf_q <= 1'b0;
        end else if (row_end) begin
            fsel     <= ~fsel;
            fill_cnt <= '0;
            fill_ovf <= 1'b0;
            tx_cnt   <= load_cnt;
            tx_ovf_q <= fill_ovf | drop;
        end else begin
            fill_cnt <= load_cnt;
            fill_ovf <= fill_ovf | drop;
        end
    end

    // Send half: slice and word pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_idx <= '0;
            beat   <= '0;
        end else if (row_end) begin
            tx_idx <= '0;
            beat   <= '0;
        end else if (tx_state == TX_SEND) begin
            if (beat == BEAT_W'(BEATS - 1)) begin
                beat   <= '0;
                tx_idx <= tx_idx + IDX_W'(1);
            end else begin
                beat <= beat + BEAT_W'(1);
            end
        end
    end

    assign last_beat = (beat == BEAT_W'(BEATS - 1)) &&
                       ((CNT_W'(tx_idx) + CNT_W'(1)) == tx_cnt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_state <= TX_IDLE;
        end else begin
            tx_state <= tx_next;
        end
    end

    always_comb begin
        tx_next = tx_state;
        unique case (tx_state)
            TX_IDLE: begin
                if (row_end && (load_cnt != '0)) begin
                    tx_next = TX_SEND;
                end
            end
            TX_SEND: begin
                if (row_end) begin
                    tx_next = (load_cnt != '0) ? TX_SEND : TX_IDLE;
                end else if (last_beat) begin
                    tx_next = TX_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        tx_word     = mem[~fsel][tx_idx];
        ser_valid   = (tx_state == TX_SEND);
        ser_data    = ser_valid ? tx_word[(WORD_W - 1) - int'(beat) * SER_W -: SER_W] : '0;
        tx_overflow = tx_ovf_q;
    end

endmodule

// File: rtl/rs_row_readout.sv
module rs_row_readout
    import rs_pkg::*;
#(
    parameter int ROWS       = 1088,
    parameter int BANKS      = 17,
    parameter int BANK_COLS  = 64,
    parameter int ROW_CYCLES = 16,
    parameter int MAX_HITS   = 8,
    parameter int WORD_W     = 32,
    parameter int SER_W      = 16,
    localparam int ROW_W     = $clog2(ROWS),
    localparam int BANK_W    = $clog2(BANKS),
    localparam int COL_W     = $clog2(BANK_COLS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [BANKS-1:0]       bank_hit_valid,
    input  logic [BANKS*COL_W-1:0] bank_hit_col,
    output logic [ROW_W-1:0]       row_addr,
    output logic                   frame_start,
    output logic [BANKS-1:0]       bank_rd,
    output logic [SER_W-1:0]       ser_data,
    output logic                   ser_valid,
    output logic                   tx_overflow
);

    localparam int SLOT_W = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1;

    scan_state_e       state;
    scan_state_e       state_next;
    logic [SLOT_W-1:0] slot_cnt;
    logic [ROW_W-1:0]  row_cnt;
    logic              scanning;
    logic              row_end;
    logic [BANKS-1:0]  grant;
    logic [BANK_W-1:0] pick_idx;
    logic [COL_W-1:0]  pick_col;
    logic [WORD_W-1:0] hit_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SCAN_IDLE;
        end else begin
            state <= state_next;
        end
    end

    always_comb begin
        state_next = state;
        unique case (state)
            SCAN_IDLE: if (start) state_next = SCAN_RUN;
            SCAN_RUN:  state_next = SCAN_RUN;
        endcase
    end

    // Row cadence: a fixed slot budget per row, wrap at the last row.
    always_ff @(posedge clk) begin
        if (!rst_n || state == SCAN_IDLE) begin
            slot_cnt <= '0;
            row_cnt  <= '0;
        end else if (slot_cnt == SLOT_W'(ROW_CYCLES - 1)) begin
            slot_cnt <= '0;
            row_cnt  <= (row_cnt == ROW_W'(ROWS - 1)) ? '0 : row_cnt + ROW_W'(1);
        end else begin
            slot_cnt <= slot_cnt + SLOT_W'(1);
        end
    end

    always_comb begin
        scanning    = (state == SCAN_RUN);
        row_end     = scanning && (slot_cnt == SLOT_W'(ROW_CYCLES - 1));
        frame_start = scanning && (slot_cnt == '0) && (row_cnt == '0);
        row_addr    = row_cnt;
        bank_rd     = grant;
    end

    rs_bank_pick #(
        .BANKS(BANKS)
    ) u_pick (
        .en   (scanning),
        .req  (bank_hit_valid),
        .grant(grant),
        .idx  (pick_idx)
    );

    assign pick_col = bank_hit_col[pick_idx * COL_W +: COL_W];
    assign hit_word = WORD_W'({row_cnt, pick_idx, pick_col});

    rs_hit_buffer #(
        .MAX_HITS(MAX_HITS),
        .WORD_W  (WORD_W),
        .SER_W   (SER_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (|grant),
        .word_in    (hit_word),
        .row_end    (row_end),
        .ser_data   (ser_data),
        .ser_valid  (ser_valid),
        .tx_overflow(tx_overflow)
    );

endmodule

// File: rtl/rs_row_readout_chk.sv
module rs_row_readout_chk #(
    parameter int ROWS       = 1088,
    parameter int BANKS      = 17,
    parameter int ROW_CYCLES = 16,
    parameter int MAX_HITS   = 8,
    parameter int WORD_W     = 32,
    parameter int SER_W      = 16,
    localparam int ROW_W     = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ROW_W-1:0] row_addr,
    input logic             frame_start,
    input logic [BANKS-1:0] bank_hit_valid,
    input logic [BANKS-1:0] bank_rd,
    input logic             ser_valid
);

    localparam int BURST_MAX = MAX_HITS * (WORD_W / SER_W);

    logic [ROW_W-1:0] row_q;
    logic [15:0]      held_q;
    logic [15:0]      burst_q;
    logic             new_row;

    assign new_row = (row_addr != row_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            held_q  <= '0;
            burst_q <= '0;
        end else begin
            row_q   <= row_addr;
            held_q  <= (new_row || frame_start) ? 16'd1 :
                       (held_q == 16'hFFFF) ? held_q : held_q + 16'd1;
            burst_q <= (new_row || frame_start) ? 16'(ser_valid) :
                       (burst_q == 16'hFFFF) ? burst_q : burst_q + 16'(ser_valid);
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_rd)); // R4
    AST_STROBE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd & ~bank_hit_valid) == '0); // R4
    AST_LOWEST_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd != '0) |-> (((bank_rd - BANKS'(1)) & bank_hit_valid) == '0)); // R4
    AST_ROW_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
        new_row |-> (held_q == 16'(ROW_CYCLES))); // R2
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        new_row |-> (row_addr == ((row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + ROW_W'(1)))); // R3
    AST_FRAME_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (row_addr == '0)); // R3
    AST_TX_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> new_row); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        burst_q <= 16'(BURST_MAX)); // R6

endmodule

bind rs_row_readout rs_row_readout_chk #(
    .ROWS      (ROWS),
    .BANKS     (BANKS),
    .ROW_CYCLES(ROW_CYCLES),
    .MAX_HITS  (MAX_HITS),
    .WORD_W    (WORD_W),
    .SER_W     (SER_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .row_addr      (row_addr),
    .frame_start   (frame_start),
    .bank_hit_valid(bank_hit_valid),
    .bank_rd       (bank_rd),
    .ser_valid     (ser_valid)
);

// File: tb/rs_row_readout_test.sv
module rs_row_readout_test;

    localparam int ROWS     = 1088;
    localparam int BANKS    = 17;
    localparam int COL_W    = 6;
    localparam int RC       = 16;
    localparam int MAXH     = 8;
    localparam int BEATS    = 2;
    localparam int QMAX     = 4;
    localparam int TOTAL    = (ROWS + 3) * RC + 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [BANKS-1:0]       bank_hit_valid = '0;
    logic [BANKS*COL_W-1:0] bank_hit_col = '0;
    logic [10:0]            row_addr;
    logic                   frame_start;
    logic [BANKS-1:0]       bank_rd;
    logic [15:0]            ser_data;
    logic                   ser_valid;
    logic                   tx_overflow;

    always #2 clk = ~clk;

    rs_row_readout uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bank_hit_valid(bank_hit_valid), .bank_hit_col(bank_hit_col),
        .row_addr(row_addr), .frame_start(frame_start), .bank_rd(bank_rd),
        .ser_data(ser_data), .ser_valid(ser_valid), .tx_overflow(tx_overflow)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int bq_col [BANKS][QMAX];
    int bq_n [BANKS];
    int bq_h [BANKS];
    logic [BANKS-1:0] rd_seen;

    logic [31:0] fill_w [MAXH];
    int          fill_n;
    bit          fill_ovf;
    logic [31:0] tx_w [MAXH];
    int          tx_n;
    bit          tx_ovf;
    bit          have_tx;
    logic [31:0] rx_w [MAXH + 2];
    int          rx_n;
    int          rx_beat;
    logic [31:0] rx_acc;
    bit          rx_gap;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R5: bits [5:0] column, [10:6] bank, [21:11] row, [31:22] zero.
    function automatic logic [31:0] hit_word(input int row, input int bank, input int col);
        return {10'b0, row[10:0], bank[4:0], col[5:0]};
    endfunction

    function automatic int lowest_valid(input logic [BANKS-1:0] v);
        for (int b = 0; b < BANKS; b++) if (v[b]) return b;
        return -1;
    endfunction

    task automatic add_hit(input int bank, input int col);
        if (bq_n[bank] < QMAX) begin
            bq_col[bank][bq_n[bank]] = col;
            bq_n[bank]++;
        end
    endtask

    // Loads the bank queues for a row and derives R6/R7 expectations.
    task automatic plan_row(input int row, input int rowi);
        int pops;
        for (int b = 0; b < BANKS; b++) begin
            bq_n[b] = 0;
            bq_h[b] = 0;
        end
        if (rowi == 1) begin
            for (int k = 0; k < 4; k++) begin add_hit(2, 10 + k); add_hit(3, 60 - k); end
        end else if (rowi == 2) begin
            for (int k = 0; k < 4; k++) begin add_hit(0, k); add_hit(5, 20 + k); end
            add_hit(16, 33);
        end else if (rowi == 3) begin
            for (int b = 0; b < BANKS; b++) add_hit(b, b + 1);
        end else if (rowi == 4) begin
            add_hit(16, 63);
        end else if (rowi == 5) begin
            add_hit(16, 0);
            add_hit(0, 63);
        end else if (rowi > 5) begin
            for (int b = 0; b < BANKS; b++) begin
                if (($urandom % 8) == 0) begin
                    int n;
                    n = 1 + int'($urandom % 3);
                    for (int k = 0; k < n; k++) add_hit(b, int'($urandom % 64));
                end
            end
        end
        pops = 0;
        fill_n = 0;
        fill_ovf = 0;
        for (int b = 0; b < BANKS; b++) begin
            for (int k = 0; k < bq_n[b]; k++) begin
                if (pops < RC) begin
                    pops++;
                    if (fill_n < MAXH) begin
                        fill_w[fill_n] = hit_word(row, b, bq_col[b][k]);
                        fill_n++;
                    end else begin
                        fill_ovf = 1;
                    end
                end
            end
        end
    endtask

    task automatic drive_banks();
        for (int b = 0; b < BANKS; b++) begin
            bank_hit_valid[b] = (bq_h[b] < bq_n[b]);
            bank_hit_col[b*COL_W +: COL_W] = (bq_h[b] < bq_n[b]) ? COL_W'(bq_col[b][bq_h[b]]) : '0;
        end
    endtask

    task automatic finish_tx();
        if (have_tx) begin
            check(rx_n == tx_n && rx_beat == 0, "R8", "words sent for row", rx_n, tx_n);
            check(!rx_gap, "R9", "burst contiguous from first cycle", rx_gap, 0);
            for (int i = 0; i < tx_n && i < rx_n; i++)
                check(rx_w[i] == tx_w[i], "R5", "hit word", rx_w[i], tx_w[i]);
        end
    endtask

    initial begin
        int seed_sink;
        seed_sink = int'($urandom(32'd2024));
        for (int b = 0; b < BANKS; b++) begin bq_n[b] = 0; bq_h[b] = 0; end
        rd_seen = '0;
        have_tx = 0;
        tx_n = 0;
        tx_ovf = 0;
        rx_n = 0;
        rx_beat = 0;
        rx_acc = '0;
        rx_gap = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(row_addr == 0 && bank_rd == 0 && frame_start == 0, "R1", "reset outputs",
              {row_addr, bank_rd, frame_start}, 0);
        check(ser_valid == 0 && ser_data == 0 && tx_overflow == 0, "R1", "reset serial",
              {ser_valid, ser_data, tx_overflow}, 0);
        // Hits offered before start must not be strobed.
        bank_hit_valid = 17'h00010;
        repeat (10) @(negedge clk);
        #1;
        check(bank_rd == 0 && ser_valid == 0 && frame_start == 0 && row_addr == 0, "R1",
              "idle before start", {bank_rd, ser_valid, frame_start}, 0);
        bank_hit_valid = '0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < TOTAL; cyc++) begin
            int slot;
            int rowi;
            int row;
            int exp_b;
            if (cyc != 0) @(negedge clk);
            for (int b = 0; b < BANKS; b++) if (rd_seen[b] && bq_h[b] < bq_n[b]) bq_h[b]++;
            slot = cyc % RC;
            rowi = cyc / RC;
            row = rowi % ROWS;
            if (slot == 0) begin
                finish_tx();
                if (rowi >= 1) begin
                    have_tx = 1;
                    tx_n = fill_n;
                    tx_ovf = fill_ovf;
                    for (int i = 0; i < MAXH; i++) tx_w[i] = fill_w[i];
                end
                rx_n = 0;
                rx_beat = 0;
                rx_gap = 0;
                plan_row(row, rowi);
            end
            drive_banks();
            #1;
            if (slot == 0 || slot == RC - 1)
                check(row_addr == 11'(row), "R2", "row address", row_addr, row);
            if (slot == 0 && (row == 0 || row == ROWS - 1 || rowi < 2))
                check(frame_start == (row == 0), "R3", "frame marker", frame_start, row == 0);
            else if (frame_start)
                check(0, "R3", "stray frame marker", 1, 0);
            if (slot == 0 && have_tx)
                check(tx_overflow == tx_ovf, "R7", "overflow flag", tx_overflow, tx_ovf);
            exp_b = lowest_valid(bank_hit_valid);
            if (exp_b >= 0 || bank_rd != 0)
                check(bank_rd == ((exp_b >= 0) ? (BANKS'(1) << exp_b) : '0), "R4",
                      "drain strobe", bank_rd, (exp_b >= 0) ? (BANKS'(1) << exp_b) : 0);
            if (rowi == 3 && slot == RC - 1)
                check(bq_n[16] == 1 && bq_h[16] == 0, "R6", "bank 16 undrained within budget",
                      bq_h[16], 0);
            rd_seen = bank_rd;
            if (ser_valid) begin
                if (slot != rx_n * BEATS + rx_beat) rx_gap = 1;
                rx_acc = {rx_acc[15:0], ser_data};
                rx_beat++;
                if (rx_beat == BEATS) begin
                    if (rx_n < MAXH + 2) rx_w[rx_n] = rx_acc;
                    rx_n++;
                    rx_beat = 0;
                end
            end else if (ser_data != 0) begin
                check(0, "R8", "data while not valid", ser_data, 0);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule